// File: doc/BRIEF.md
# Queued Command Bridge to a 16-bit Register Port

This block lets a processor reach a 16-bit register port, with a 10-bit address and a ready handshake, through two 16-entry queues. The host writes 32-bit command words into a command queue. An engine pops each word and carries out a read, a write or a no-op on the port. For every command it runs, including writes and no-ops, the engine pushes exactly one 16-bit result word into a result queue.

Read data lags by one command. The entry that a read command produces holds the value captured by the previous read. The data the read itself returns appears in the entry of the next command. To read one port register, the host therefore queues a read followed by a no-op. It then polls the status register until the command queue reports empty, pops two entries and keeps the second.

The host side is a simple word-addressed register bus whose reads are combinational. Sticky error flags, a mask and a level interrupt report a push into a full command queue and a pop from an empty result queue.

Top module: `cmdq_reg_bridge`

## Requirements
- R1: After reset, configuration reads 0x00000000, status reads 0x00000401, interrupt status reads 0, interrupt mask reads 0x3, and irq is low.
- R2: A command word holds the opcode in bits 29:26, the port address in bits 25:16 and the write data in bits 15:0. Opcode 1 reads, opcode 2 writes, and opcode 0 and every other opcode act as a no-op that never drives the port.
- R3: Every executed command, whether a read, a write or a no-op, pushes exactly one entry into the result queue.
- R4: An entry holds, in bits 15:0, the value captured by the most recent completed read, which is 0 after reset; bits 31:16 read 0. A read's data therefore shows up in the entry of the following command.
- R5: The port enable is high for one cycle per transaction, and no new enable is raised until ready has been returned for the previous one.
- R6: Status (address 0x0C) has bit 10 set only when the command queue is empty and no port transaction is outstanding. Bit 2 is command queue full, bit 0 is result queue empty, and bit 1 is result queue full.
- R7: Configuration (address 0x00) stores bit 31 (enable), bits 13:12 (edge options) and bits 9:8 (divider); all other bits read 0. While enable is 0 no command runs, and queued commands run in their queued order once enable is set.
- R8: A command-queue write (address 0x10) while 16 commands are queued is dropped and sets interrupt status bit 0.
- R9: A result-queue read (address 0x14) while the queue is empty returns 0 and sets interrupt status bit 1.
- R10: Interrupt status (address 0x04) bits are sticky and are cleared by writing 1 to them. irq is high when any status bit has a 0 in the mask (address 0x08).
- R11: While the result queue is full the engine starts no command; it resumes once the host pops an entry.
- R12: Register 0x18 stores and returns all 32 bits; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (pops the result queue at 0x14) |
| bus_addr | input | 5 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational |
| irq | output | 1 | Level interrupt |
| prt_en | output | 1 | Port transaction enable, one cycle |
| prt_we | output | 1 | Port write enable |
| prt_addr | output | 10 | Port register address |
| prt_di | output | 16 | Data driven to the port |
| prt_do | input | 16 | Data returned by the port |
| prt_rdy | input | 1 | Port ready, ends a transaction |

## Verification
A wrong held-data register shows up in the very next popped entry: either a dummy entry carries the wrong value, or the second entry of a read pair does not match the port's register contents. A lost or doubled result push changes the result-queue count. That appears within one command as a wrong empty or full flag in status, or as an underflow flag set too early. A premature empty report or a missing stall shows at the ports as overlapping enables, or as status bit 10 rising while the port still has a transaction outstanding.

// File: rtl/cqb_pkg.sv
package cqb_pkg;
    localparam int BUS_AW = 5;

    localparam logic [BUS_AW-1:0] RA_CFG  = 5'h00;
    localparam logic [BUS_AW-1:0] RA_IST  = 5'h04;
    localparam logic [BUS_AW-1:0] RA_IMSK = 5'h08;
    localparam logic [BUS_AW-1:0] RA_STAT = 5'h0C;
    localparam logic [BUS_AW-1:0] RA_CMDQ = 5'h10;
    localparam logic [BUS_AW-1:0] RA_RESQ = 5'h14;
    localparam logic [BUS_AW-1:0] RA_MCTL = 5'h18;

    localparam logic [3:0] OPC_RD = 4'd1;
    localparam logic [3:0] OPC_WR = 4'd2;

    localparam int CMD_W = 30;

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;
endpackage

// File: rtl/cqb_fifo.sv
module cqb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t         p_d, p_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    always_comb begin
        empty   = (p_q.cnt == '0);
        full    = (p_q.cnt == (AW+1)'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        p_d     = p_q;
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
        p_d.cnt = p_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        head    = mem[p_q.rp];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp] <= din;
    end
endmodule

// File: rtl/cqb_engine.sv
module cqb_engine
    import cqb_pkg::*;
#(
    parameter int PA_W = 10,
    parameter int PD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             cmd_empty,
    input  logic             res_full,
    output logic             cmd_pop,
    output logic             res_push,
    output logic [PD_W-1:0]  res_data,
    output logic             busy,
    output logic             prt_en,
    output logic             prt_we,
    output logic [PA_W-1:0]  prt_addr,
    output logic [PD_W-1:0]  prt_di,
    input  logic [PD_W-1:0]  prt_do,
    input  logic             prt_rdy
);
    typedef struct packed {
        eng_state_e      st;
        logic            en;
        logic            we;
        logic [PA_W-1:0] addr;
        logic [PD_W-1:0] di;
        logic [PD_W-1:0] held;
    } eng_t;

    eng_t       e_d, e_q;
    logic [3:0] opc;

    always_comb begin
        e_d      = e_q;
        e_d.en   = 1'b0;
        cmd_pop  = 1'b0;
        res_push = 1'b0;
        res_data = e_q.held;
        opc      = cmd_word[29:26];
        case (e_q.st)
            ENG_IDLE: begin
                if (enable && !cmd_empty && !res_full) begin
                    cmd_pop = 1'b1;
                    if (opc == OPC_RD || opc == OPC_WR) begin
                        e_d.st   = ENG_WAIT;
                        e_d.en   = 1'b1;
                        e_d.we   = (opc == OPC_WR);
                        e_d.addr = cmd_word[16 +: PA_W];
                        e_d.di   = cmd_word[0 +: PD_W];
                    end else begin
                        res_push = 1'b1;
                    end
                end
            end
            default: begin
                if (prt_rdy) begin
                    res_push = 1'b1;
                    e_d.st   = ENG_IDLE;
                    if (!e_q.we) e_d.held = prt_do;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '{st: ENG_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign busy     = (e_q.st == ENG_WAIT);
    assign prt_en   = e_q.en;
    assign prt_we   = e_q.we;
    assign prt_addr = e_q.addr;
    assign prt_di   = e_q.di;
endmodule

// File: rtl/cmdq_reg_bridge.sv
module cmdq_reg_bridge
    import cqb_pkg::*;
#(
    parameter int CMD_DEPTH = 16,
    parameter int RES_DEPTH = 16,
    parameter int PA_W      = 10,
    parameter int PD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              prt_en,
    output logic              prt_we,
    output logic [PA_W-1:0]   prt_addr,
    output logic [PD_W-1:0]   prt_di,
    input  logic [PD_W-1:0]   prt_do,
    input  logic              prt_rdy
);
    typedef struct packed {
        logic        cfg_en;
        logic [1:0]  cfg_edge;
        logic [1:0]  cfg_div;
        logic [1:0]  ist;
        logic [1:0]  imsk;
        logic [31:0] mctl;
    } regs_t;

    regs_t            r_d, r_q;
    logic             cmd_push, cmd_pop, cmd_empty, cmd_full;
    logic [CMD_W-1:0] cmd_head;
    logic             res_push, res_pop, res_empty, res_full;
    logic [PD_W-1:0]  res_din, res_head;
    logic             eng_busy, cmd_done, ovf_evt, unf_evt;
    logic             cfg_en_w;
    logic [1:0]       ist_w;

    cqb_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_push), .din(bus_wdata[CMD_W-1:0]),
        .pop(cmd_pop), .head(cmd_head),
        .empty(cmd_empty), .full(cmd_full)
    );

    cqb_fifo #(.W(PD_W), .DEPTH(RES_DEPTH)) u_resq (
        .clk(clk), .rst_n(rst_n),
        .push(res_push), .din(res_din),
        .pop(res_pop), .head(res_head),
        .empty(res_empty), .full(res_full)
    );

    cqb_engine #(.PA_W(PA_W), .PD_W(PD_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(r_q.cfg_en),
        .cmd_word(cmd_head), .cmd_empty(cmd_empty), .res_full(res_full),
        .cmd_pop(cmd_pop), .res_push(res_push), .res_data(res_din),
        .busy(eng_busy),
        .prt_en(prt_en), .prt_we(prt_we), .prt_addr(prt_addr), .prt_di(prt_di),
        .prt_do(prt_do), .prt_rdy(prt_rdy)
    );

    always_comb begin
        cmd_done = cmd_empty && !eng_busy;
        cmd_push = bus_wr && (bus_addr == RA_CMDQ);
        res_pop  = bus_rd && (bus_addr == RA_RESQ);
        ovf_evt  = cmd_push && cmd_full;
        unf_evt  = res_pop && res_empty;

        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                RA_CFG: begin
                    r_d.cfg_en   = bus_wdata[31];
                    r_d.cfg_edge = bus_wdata[13:12];
                    r_d.cfg_div  = bus_wdata[9:8];
                end
                RA_IST:  r_d.ist  = r_q.ist & ~bus_wdata[1:0];
                RA_IMSK: r_d.imsk = bus_wdata[1:0];
                RA_MCTL: r_d.mctl = bus_wdata;
                default: ;
            endcase
        end
        r_d.ist = r_d.ist | {unf_evt, ovf_evt};

        bus_rdata = '0;
        case (bus_addr)
            RA_CFG: begin
                bus_rdata[31]    = r_q.cfg_en;
                bus_rdata[13:12] = r_q.cfg_edge;
                bus_rdata[9:8]   = r_q.cfg_div;
            end
            RA_IST:  bus_rdata[1:0] = r_q.ist;
            RA_IMSK: bus_rdata[1:0] = r_q.imsk;
            RA_STAT: begin
                bus_rdata[10] = cmd_done;
                bus_rdata[2]  = cmd_full;
                bus_rdata[1]  = res_full;
                bus_rdata[0]  = res_empty;
            end
            RA_RESQ: bus_rdata[PD_W-1:0] = res_empty ? '0 : res_head;
            RA_MCTL: bus_rdata = r_q.mctl;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{imsk: 2'b11, default: '0};
        else        r_q <= r_d;
    end

    assign irq      = |(r_q.ist & ~r_q.imsk);
    assign cfg_en_w = r_q.cfg_en;
    assign ist_w    = r_q.ist;
endmodule

// File: rtl/cqb_chk.sv
module cqb_chk
    import cqb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              prt_en,
    input logic              prt_rdy,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              cmd_full,
    input logic              cmd_done,
    input logic              cfg_en,
    input logic [1:0]        ist
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (prt_en && !prt_rdy) pend_q <= 1'b1;
        else if (prt_rdy)            pend_q <= 1'b0;
    end

    // R5
    en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prt_en |=> !prt_en);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prt_en |-> !pend_q);

    // R6
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q || prt_en) |-> !cmd_done);

    // R8
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_CMDQ && cmd_full) |=> ist[0]);

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prt_en |-> $past(cfg_en));
endmodule

bind cmdq_reg_bridge cqb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .prt_en(prt_en), .prt_rdy(prt_rdy),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .cmd_full(cmd_full),
    .cmd_done(cmd_done), .cfg_en(cfg_en_w), .ist(ist_w)
);

// File: tb/cmdq_reg_bridge_test.sv
module cmdq_reg_bridge_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [4:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq, prt_en, prt_we;
    logic [9:0]  prt_addr;
    logic [15:0] prt_di;
    logic [15:0] prt_do = 0;
    logic        prt_rdy = 0;

    int checks = 0, errors = 0, en_seen = 0;
    logic [15:0] dmem [1024];
    logic [15:0] shadow [1024];
    logic [15:0] held = 0;

    always #10 clk = ~clk;

    cmdq_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .prt_en(prt_en), .prt_we(prt_we), .prt_addr(prt_addr),
        .prt_di(prt_di), .prt_do(prt_do), .prt_rdy(prt_rdy)
    );

    function automatic logic [15:0] seed(input int a);
        return 16'((a * 613 + 16'h1234) & 16'hFFFF);
    endfunction

    function automatic logic [31:0] cw(input logic [3:0] op, input logic [9:0] a,
                                       input logic [15:0] d);
        return {2'b00, op, a, d};
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) begin
            dmem[i]   = seed(i);
            shadow[i] = seed(i);
        end
    end

    // port model: ready 1..3 cycles after enable
    logic       m_pend = 0, m_we = 0;
    logic [9:0] m_a = 0;
    logic [15:0] m_di = 0;
    int         m_cnt = 0, m_rot = 0;
    always @(posedge clk) begin
        prt_rdy <= 1'b0;
        if (prt_en) begin
            m_pend  <= 1'b1;
            m_we    <= prt_we;
            m_a     <= prt_addr;
            m_di    <= prt_di;
            m_cnt   <= m_rot % 3;
            m_rot   <= m_rot + 1;
            en_seen <= en_seen + 1;
        end else if (m_pend) begin
            if (m_cnt == 0) begin
                prt_rdy <= 1'b1;
                m_pend  <= 1'b0;
                if (m_we) dmem[m_a] <= m_di;
                else      prt_do <= dmem[m_a];
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            hread(5'h0C, s);
            if (s[10]) return;
        end
        chk("R6 done timeout", 0, 1);
    endtask

    task automatic pop_expect(input string req, input logic [15:0] v);
        logic [31:0] d;
        hread(5'h14, d);
        chk(req, d, {16'h0, v});
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        hread(5'h00, d); chk("R1 cfg", d, 32'h0);
        hread(5'h0C, d); chk("R1 status", d, 32'h401);
        hread(5'h04, d); chk("R1 ist", d, 32'h0);
        hread(5'h08, d); chk("R1 mask", d, 32'h3);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R7 config fields
        hwrite(5'h00, 32'hFFFF_FFFF);
        hread(5'h00, d); chk("R7 cfg readback", d, 32'h8000_3300);
        hwrite(5'h00, 32'h0000_0100);
        hread(5'h00, d); chk("R7 cfg disabled", d, 32'h0000_0100);

        // R12 misc control and unmapped address
        hwrite(5'h18, 32'hA5C3_0F1E);
        hread(5'h18, d); chk("R12 mctl", d, 32'hA5C3_0F1E);
        hread(5'h1C, d); chk("R12 unmapped", d, 32'h0);

        // R7 nothing runs while disabled, then runs in order
        base = en_seen;
        hwrite(5'h10, cw(4'd1, 10'd77, 16'h0));
        hwrite(5'h10, cw(4'd2, 10'd77, 16'hBEEF));
        hwrite(5'h10, cw(4'd1, 10'd77, 16'h0));
        hwrite(5'h10, cw(4'd0, 10'd0, 16'h0));
        repeat (20) @(negedge clk);
        chk("R7 no port access while disabled", en_seen, base);
        hread(5'h0C, d); chk("R7 queued status", d, 32'h001);
        hwrite(5'h00, 32'h8000_0100);
        wait_done();
        chk("R5 three transactions", en_seen, base + 3);
        pop_expect("R4 first dummy", held);
        pop_expect("R4 read lands in write entry", shadow[77]);
        pop_expect("R4 second read own entry", shadow[77]);
        shadow[77] = 16'hBEEF; held = 16'hBEEF;
        pop_expect("R4 read after write", 16'hBEEF);
        hread(5'h0C, d); chk("R6 idle status", d, 32'h401);

        // R4 sweep of read pairs over the address space
        for (int a = 0; a < 1024; a += 61) begin
            hwrite(5'h10, cw(4'd1, 10'(a), 16'h0));
            hwrite(5'h10, cw(4'd0, 10'd0, 16'h0));
            wait_done();
            pop_expect("R4 dummy entry", held);
            pop_expect("R4 read data", shadow[a]);
            held = shadow[a];
        end

        // R2 R3 writes yield one entry each and reach the port
        for (int k = 0; k < 6; k++) begin
            int wa;
            logic [15:0] wv;
            wa = (k * 173 + 9) % 1024;
            wv = 16'(k * 4099 + 16'h0F0F);
            base = en_seen;
            hwrite(5'h10, cw(4'd2, 10'(wa), wv));
            wait_done();
            chk("R3 write uses port once", en_seen, base + 1);
            pop_expect("R3 write entry", held);
            hread(5'h0C, d); chk("R3 single entry", d, 32'h401);
            shadow[wa] = wv;
            hwrite(5'h10, cw(4'd1, 10'(wa), 16'h0));
            hwrite(5'h10, cw(4'd0, 10'd0, 16'h0));
            wait_done();
            pop_expect("R2 dummy", held);
            pop_expect("R2 write data field", wv);
            held = wv;
        end

        // R2 unknown opcodes are no-ops
        for (int op = 3; op < 16; op++) begin
            base = en_seen;
            hwrite(5'h10, cw(4'(op), 10'd5, 16'hABCD));
            wait_done();
            chk("R2 unknown opcode no port", en_seen, base);
            pop_expect("R3 unknown opcode entry", held);
        end

        // R8 overflow, R10 mask and clear
        hwrite(5'h00, 32'h0);
        for (int i = 0; i < 17; i++) hwrite(5'h10, cw(4'd0, 10'd0, 16'h0));
        hread(5'h0C, d); chk("R6 cmd full status", d, 32'h005);
        hread(5'h04, d); chk("R8 overflow flag", d, 32'h1);
        chk("R10 masked irq", {31'h0, irq}, 32'h0);
        hwrite(5'h08, 32'h0);
        chk("R10 unmasked irq", {31'h0, irq}, 32'h1);
        hwrite(5'h04, 32'h1);
        hread(5'h04, d); chk("R10 w1c", d, 32'h0);
        chk("R10 irq cleared", {31'h0, irq}, 32'h0);

        // R11 stall on full result queue
        hwrite(5'h00, 32'h8000_0000);
        wait_done();
        hread(5'h0C, d); chk("R6 result full", d, 32'h402);
        hwrite(5'h10, cw(4'd0, 10'd0, 16'h0));
        repeat (10) @(negedge clk);
        hread(5'h0C, d); chk("R11 stalled", d, 32'h002);
        pop_expect("R3 entry", held);
        wait_done();
        hread(5'h0C, d); chk("R11 resumed", d, 32'h402);
        for (int i = 0; i < 16; i++) pop_expect("R3 drain", held);

        // R9 underflow
        pop_expect("R9 empty pop", 16'h0);
        hread(5'h04, d); chk("R9 underflow flag", d, 32'h2);
        chk("R10 irq underflow", {31'h0, irq}, 32'h1);
        hwrite(5'h04, 32'h2);
        hread(5'h04, d); chk("R10 clear underflow", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule